// File: doc/BRIEF.md
# Programmable Static Memory Bus Controller

This block bridges a 32-bit internal request port to an external asynchronous bus for SRAM, flash, ROM and memory-mapped peripherals. The external bus has separate address and data lines, a 16-bit data path and six active-low chip selects. Each chip select carries its own setting for device width (8 or 16 bits), strobe wait states, a post-access recovery delay, write protection and the use of an external wait handshake. A word request to a narrow device becomes a run of device-width beats: write data is scattered over them and read data is gathered from them into the 32-bit response.

A requester holds `req_valid` and its request fields steady until `req_ready` pulses for one cycle. In that cycle the response data and error flag are valid. A per-access watchdog counts busy cycles. If an access hangs, the watchdog aborts it, frees the bus, answers the requester with an error and raises a warm-reset request. A write to a protected chip select never reaches the bus. It is acknowledged, and a sticky flag records that it was blocked.

Top module: `smc_top`

## Requirements
- R1: `req_addr[28:26]` selects chip select 0..5, and `mem_cs_n[i]` is the only chip select driven low for index i. Bits [25:0], with [1:0] forced to zero, form the device word base. Index 6 or 7 drives no chip select and is answered by a `req_ready` pulse with `rsp_err`=1.
- R2: For a 16-bit chip select (`cfg_wide[i]`=1) an access is two beats, at base+0 and then base+2. Beat h carries bytes 2h and 2h+1 on `mem_dout[15:0]`. During a write strobe, `mem_we_n[1:0]` equals the inverse of `req_be[2h+1:2h]`. On a read, the halfword from beat h lands in `rsp_rdata[16h+15:16h]`.
- R3: For an 8-bit chip select (`cfg_wide[i]`=0) an access is four beats, at base+0 to base+3 in ascending order. Byte b travels on bits [7:0] of the data bus. During a write strobe, `mem_we_n[0]` equals the inverse of `req_be[b]` and `mem_we_n[1]` stays high. Read byte b lands in `rsp_rdata[8b+7:8b]`.
- R4: With external wait off, every beat's strobe lasts exactly W+1 cycles, where W is `cfg_wait[6i+5:6i]` (0..63).
- R5: After each strobe there is one cycle with chip select, address and write data unchanged and all strobes high. Then P cycles (P = `cfg_post[5i+4:5i]`, 0..31) follow with no chip select, before the next beat or the acknowledge. The strobe of a beat therefore begins P+1 cycles after the previous strobe ended.
- R6: When `cfg_ext[i]`=1, a strobe that has served its W wait cycles is extended until `mem_wait_n` is sampled low at a clock edge.
- R7: A write to a chip select with `cfg_wp[i]`=1 produces no chip select or write strobe. It is acknowledged with `rsp_err`=0 and sets `wp_err`, which stays high until reset. The protected location keeps its data.
- R8: When an access has been busy for more than `cfg_tmo` cycles, it is aborted. `req_ready` pulses with `rsp_err`=1, all chip selects and strobes are high in that cycle, and `warm_rst_req` goes high and stays high until reset.
- R9: `mem_oe_n` goes low only during read strobes and `mem_we_n` only during write strobes. `req_ready` is high for exactly one cycle per request.
- R10: During and after reset, all chip selects, `mem_oe_n` and both `mem_we_n` bits are high, and `req_ready`, `wp_err` and `warm_rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request pending, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | [28:26] chip select index, [25:0] byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables of the write word |
| req_ready | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 32 | Gathered read data, valid with req_ready |
| rsp_err | output | 1 | Error response, valid with req_ready |
| cfg_wide | input | 6 | Per chip select: 1 = 16-bit device |
| cfg_wait | input | 36 | Wait states, 6 bits per chip select |
| cfg_post | input | 30 | Post-access delay, 5 bits per chip select |
| cfg_wp | input | 6 | Per chip select write protection |
| cfg_ext | input | 6 | Per chip select external wait enable |
| cfg_tmo | input | 16 | Watchdog limit in busy cycles |
| mem_cs_n | output | 6 | Chip selects, active low |
| mem_addr | output | 26 | Device byte address |
| mem_dout | output | 16 | Write data to the bus |
| mem_dout_en | output | 1 | Enable for the data bus drivers |
| mem_din | input | 16 | Read data from the bus |
| mem_oe_n | output | 1 | Output enable (read strobe), active low |
| mem_we_n | output | 2 | Byte write strobes, active low |
| mem_wait_n | input | 1 | External wait/acknowledge, low = done |
| wp_err | output | 1 | Sticky blocked-write flag |
| warm_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
Word writes followed by read-back run on a 16-bit, an 8-bit and an externally paced chip select. Full and sparse byte-enable patterns (0101, 1010) separate correct lane steering from swapped or shifted lanes, because the bench's own device model only stores bytes whose strobe bit is low. Strobe widths, beat counts and the gaps between strobes are measured at the pins. This sets wait-state counting apart from post-delay counting and from external pacing. A protected write, an unmapped index and a permanently stalled handshake cover the paths that must not touch the bus or that must abandon it.

// File: rtl/smc_pkg.sv
package smc_pkg;
    localparam int BUS_W  = 16;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STRB,
        ST_HOLD,
        ST_POST,
        ST_DONE
    } smc_state_e;
endpackage

// File: rtl/smc_csdec.sv
module smc_csdec #(
    parameter int NUM_CS = 6,
    parameter int SEL_W  = 3,
    parameter int WAIT_W = 6,
    parameter int POST_W = 5
) (
    input  logic [SEL_W-1:0]         sel,
    input  logic [NUM_CS-1:0]        cfg_wide,
    input  logic [NUM_CS*WAIT_W-1:0] cfg_wait,
    input  logic [NUM_CS*POST_W-1:0] cfg_post,
    input  logic [NUM_CS-1:0]        cfg_wp,
    input  logic [NUM_CS-1:0]        cfg_ext,
    output logic                     hit,
    output logic                     wide,
    output logic [WAIT_W-1:0]        wst,
    output logic [POST_W-1:0]        post,
    output logic                     wp,
    output logic                     ext
);
    always_comb begin
        hit  = 1'b0;
        wide = 1'b0;
        wst  = '0;
        post = '0;
        wp   = 1'b0;
        ext  = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (sel == SEL_W'(i)) begin
                hit  = 1'b1;
                wide = cfg_wide[i];
                wst  = cfg_wait[i*WAIT_W +: WAIT_W];
                post = cfg_post[i*POST_W +: POST_W];
                wp   = cfg_wp[i];
                ext  = cfg_ext[i];
            end
        end
    end
endmodule

// File: rtl/smc_lane.sv
module smc_lane
    import smc_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              wide,
    input  logic [1:0]        beat,
    input  logic [ADDR_W-1:0] base,
    input  logic [WORD_W-1:0] wdata,
    input  logic [3:0]        be,
    input  logic [BUS_W-1:0]  din,
    input  logic [WORD_W-1:0] rdata_cur,
    output logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  dout,
    output logic [1:0]        wen,
    output logic [WORD_W-1:0] rdata_nxt
);
    always_comb begin
        rdata_nxt = rdata_cur;
        if (wide) begin
            addr = base + ADDR_W'({beat[0], 1'b0});
            dout = wdata[16*beat[0] +: 16];
            wen  = be[2*beat[0] +: 2];
            rdata_nxt[16*beat[0] +: 16] = din;
        end else begin
            addr = base + ADDR_W'(beat);
            dout = {8'h00, wdata[8*beat +: 8]};
            wen  = {1'b0, be[beat]};
            rdata_nxt[8*beat +: 8] = din[7:0];
        end
    end
endmodule

// File: rtl/smc_wdog.sv
module smc_wdog #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q != '1)
            cnt_d = cnt_q + TMO_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q >= limit);

    // R8: the count restarts at zero for every access
    a_r8_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/smc_top.sv
module smc_top
    import smc_pkg::*;
#(
    parameter int NUM_CS = 6,
    parameter int ADDR_W = 26,
    parameter int WAIT_W = 6,
    parameter int POST_W = 5,
    parameter int TMO_W  = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_valid,
    input  logic                                        req_write,
    input  logic [ADDR_W+$clog2(NUM_CS)-1:0]            req_addr,
    input  logic [31:0]                                 req_wdata,
    input  logic [3:0]                                  req_be,
    output logic                                        req_ready,
    output logic [31:0]                                 rsp_rdata,
    output logic                                        rsp_err,
    input  logic [NUM_CS-1:0]                           cfg_wide,
    input  logic [NUM_CS*WAIT_W-1:0]                    cfg_wait,
    input  logic [NUM_CS*POST_W-1:0]                    cfg_post,
    input  logic [NUM_CS-1:0]                           cfg_wp,
    input  logic [NUM_CS-1:0]                           cfg_ext,
    input  logic [TMO_W-1:0]                            cfg_tmo,
    output logic [NUM_CS-1:0]                           mem_cs_n,
    output logic [ADDR_W-1:0]                           mem_addr,
    output logic [15:0]                                 mem_dout,
    output logic                                        mem_dout_en,
    input  logic [15:0]                                 mem_din,
    output logic                                        mem_oe_n,
    output logic [1:0]                                  mem_we_n,
    input  logic                                        mem_wait_n,
    output logic                                        wp_err,
    output logic                                        warm_rst_req
);
    localparam int SEL_W  = $clog2(NUM_CS);
    localparam int REQ_AW = ADDR_W + SEL_W;
    localparam int CNT_W  = (WAIT_W > POST_W) ? WAIT_W : POST_W;

    typedef struct packed {
        smc_state_e        state;
        logic [SEL_W-1:0]  sel;
        logic              write;
        logic [ADDR_W-1:0] base;
        logic [31:0]       wdata;
        logic [3:0]        be;
        logic [1:0]        beat;
        logic [CNT_W-1:0]  cnt;
        logic [31:0]       rdata;
        logic              err;
        logic              wpf;
        logic              warm;
    } regs_t;

    regs_t d, q;

    logic [SEL_W-1:0]  dec_sel;
    logic              dec_hit, dec_wide, dec_wp, dec_ext;
    logic [WAIT_W-1:0] dec_wst;
    logic [POST_W-1:0] dec_post;
    logic [ADDR_W-1:0] lane_addr;
    logic [15:0]       lane_dout;
    logic [1:0]        lane_wen;
    logic [31:0]       lane_rdata;
    logic              wd_run, wd_expire;
    logic              last_beat, in_bus, in_strb;

    assign dec_sel = (q.state == ST_IDLE) ? req_addr[REQ_AW-1 -: SEL_W] : q.sel;

    smc_csdec #(.NUM_CS(NUM_CS), .SEL_W(SEL_W), .WAIT_W(WAIT_W), .POST_W(POST_W)) u_dec (
        .sel(dec_sel), .cfg_wide(cfg_wide), .cfg_wait(cfg_wait), .cfg_post(cfg_post),
        .cfg_wp(cfg_wp), .cfg_ext(cfg_ext), .hit(dec_hit), .wide(dec_wide),
        .wst(dec_wst), .post(dec_post), .wp(dec_wp), .ext(dec_ext)
    );

    smc_lane #(.ADDR_W(ADDR_W)) u_lane (
        .wide(dec_wide), .beat(q.beat), .base(q.base), .wdata(q.wdata), .be(q.be),
        .din(mem_din), .rdata_cur(q.rdata), .addr(lane_addr), .dout(lane_dout),
        .wen(lane_wen), .rdata_nxt(lane_rdata)
    );

    assign wd_run = (q.state == ST_STRB) || (q.state == ST_HOLD) || (q.state == ST_POST);

    smc_wdog #(.TMO_W(TMO_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .run(wd_run), .limit(cfg_tmo), .expire(wd_expire)
    );

    assign last_beat = dec_wide ? (q.beat == 2'd1) : (q.beat == 2'd3);

    // next-state logic
    always_comb begin
        logic advance;
        d       = q;
        advance = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.sel   = req_addr[REQ_AW-1 -: SEL_W];
                    d.write = req_write;
                    d.base  = req_addr[ADDR_W-1:0] & ~ADDR_W'(3);
                    d.wdata = req_wdata;
                    d.be    = req_be;
                    d.beat  = 2'd0;
                    d.err   = 1'b0;
                    d.rdata = '0;
                    if (!dec_hit) begin
                        d.err   = 1'b1;
                        d.state = ST_DONE;
                    end else if (req_write && dec_wp) begin
                        d.wpf   = 1'b1;
                        d.state = ST_DONE;
                    end else begin
                        d.cnt   = CNT_W'(dec_wst);
                        d.state = ST_STRB;
                    end
                end
            end
            ST_STRB: begin
                if (wd_expire) begin
                    d.state = ST_DONE;
                    d.err   = 1'b1;
                    d.warm  = 1'b1;
                end else if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else if (!dec_ext || !mem_wait_n) begin
                    if (!q.write) d.rdata = lane_rdata;
                    d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (wd_expire) begin
                    d.state = ST_DONE;
                    d.err   = 1'b1;
                    d.warm  = 1'b1;
                end else if (dec_post != '0) begin
                    d.cnt   = CNT_W'(dec_post - POST_W'(1));
                    d.state = ST_POST;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_POST: begin
                if (wd_expire) begin
                    d.state = ST_DONE;
                    d.err   = 1'b1;
                    d.warm  = 1'b1;
                end else if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else begin
                    advance = 1'b1;
                end
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
        if (advance) begin
            if (last_beat) begin
                d.state = ST_DONE;
            end else begin
                d.beat  = q.beat + 2'd1;
                d.cnt   = CNT_W'(dec_wst);
                d.state = ST_STRB;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // bus outputs
    assign in_strb = (q.state == ST_STRB);
    assign in_bus  = in_strb || (q.state == ST_HOLD);

    always_comb begin
        for (int i = 0; i < NUM_CS; i++)
            mem_cs_n[i] = !(in_bus && (q.sel == SEL_W'(i)));
    end

    assign mem_addr     = lane_addr;
    assign mem_dout     = lane_dout;
    assign mem_dout_en  = in_bus && q.write;
    assign mem_oe_n     = !(in_strb && !q.write);
    assign mem_we_n     = (in_strb && q.write) ? ~lane_wen : 2'b11;
    assign req_ready    = (q.state == ST_DONE);
    assign rsp_rdata    = q.rdata;
    assign rsp_err      = q.err;
    assign wp_err       = q.wpf;
    assign warm_rst_req = q.warm;

    // checks
    logic bus_strb;
    assign bus_strb = !mem_oe_n || (mem_we_n != 2'b11);

    a_r9_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && (mem_we_n != 2'b11)));

    a_r1_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    a_r5_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_strb) && !req_ready) |->
            ($stable(mem_cs_n) && $stable(mem_addr) && $stable(mem_dout)));

    a_r8_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warm_rst_req) |-> (req_ready && rsp_err && mem_oe_n && (&mem_cs_n)));

    a_r10_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_err || warm_rst_req) |=> ($past(wp_err) -> wp_err) && ($past(warm_rst_req) -> warm_rst_req));

    for (genvar g = 0; g < NUM_CS; g++) begin : g_wp_chk
        a_r7_wp_no_we: assert property (@(posedge clk) disable iff (!rst_n)
            (!mem_cs_n[g] && cfg_wp[g]) |-> (mem_we_n == 2'b11));
    end
endmodule

// File: tb/sim_smc_top.sv
module sim_smc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [28:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, rsp_err;
    logic [31:0] rsp_rdata;
    logic [5:0]  cfg_wide, cfg_wp, cfg_ext;
    logic [35:0] cfg_wait;
    logic [29:0] cfg_post;
    logic [15:0] cfg_tmo;
    logic [5:0]  mem_cs_n;
    logic [25:0] mem_addr;
    logic [15:0] mem_dout, mem_din;
    logic        mem_dout_en, mem_oe_n, mem_wait_n;
    logic [1:0]  mem_we_n;
    logic        wp_err, warm_rst_req;

    always #2 clk = ~clk;

    smc_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cfg_wide(cfg_wide), .cfg_wait(cfg_wait), .cfg_post(cfg_post),
        .cfg_wp(cfg_wp), .cfg_ext(cfg_ext), .cfg_tmo(cfg_tmo),
        .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_wait_n(mem_wait_n),
        .wp_err(wp_err), .warm_rst_req(warm_rst_req)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // device model and independent shadow of its contents
    logic [7:0] dev_mem [0:1535];
    logic [7:0] shadow  [0:1535];
    bit force_hang = 1'b0;
    int ext_cnt = 0;

    function automatic logic [7:0] init_byte(int cs, int a);
        return 8'((cs * 37 + a * 11 + 5) & 255);
    endfunction

    initial begin
        for (int c = 0; c < 6; c++)
            for (int a = 0; a < 256; a++) begin
                dev_mem[c*256+a] = init_byte(c, a);
                shadow[c*256+a]  = init_byte(c, a);
            end
    end

    function automatic int act_cs();
        for (int i = 0; i < 6; i++) if (!mem_cs_n[i]) return i;
        return -1;
    endfunction

    always_comb begin
        int c, a;
        c = act_cs();
        a = int'(mem_addr[7:0]);
        mem_din = 16'h0;
        if (c >= 0) begin
            if (cfg_wide[c]) mem_din = {dev_mem[c*256 + (a | 1)], dev_mem[c*256 + (a & 254)]};
            else             mem_din = {8'h00, dev_mem[c*256 + a]};
        end
    end

    always @(posedge clk) begin
        int c, a;
        c = act_cs();
        a = int'(mem_addr[7:0]);
        if (c >= 0) begin
            if (cfg_wide[c]) begin
                if (!mem_we_n[0]) dev_mem[c*256 + (a & 254)] = mem_dout[7:0];
                if (!mem_we_n[1]) dev_mem[c*256 + (a | 1)]   = mem_dout[15:8];
            end else if (!mem_we_n[0]) begin
                dev_mem[c*256 + a] = mem_dout[7:0];
            end
        end
        if (!mem_oe_n || mem_we_n != 2'b11) ext_cnt = ext_cnt + 1;
        else                                 ext_cnt = 0;
    end

    assign mem_wait_n = force_hang ? 1'b1 : !((!mem_oe_n || mem_we_n != 2'b11) && ext_cnt >= 5);

    // pin monitor: strobe widths, gaps, counts
    int cyc = 0, oe_start = 0, oe_end = 0, last_len = 0, last_gap = 0;
    int oe_pulses = 0, we_cycles = 0, cs_cycles = 0;
    logic prev_oe_n = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!mem_oe_n && prev_oe_n) begin
                last_gap = cyc - oe_end;
                oe_start = cyc;
                oe_pulses++;
            end
            if (mem_oe_n && !prev_oe_n) begin
                oe_end   = cyc;
                last_len = cyc - oe_start;
            end
            if (mem_we_n != 2'b11) we_cycles++;
            if (mem_cs_n != 6'h3f) cs_cycles++;
        end
        prev_oe_n = mem_oe_n;
    end

    // scoreboard
    logic [31:0] q_data[$];
    logic        q_err[$];
    bit          q_cmp[$];
    string       q_tag[$];

    always @(negedge clk) begin
        if (rst_n && req_ready) begin
            if (q_tag.size() == 0) begin
                chk("R9 unexpected ack", 32'h1, 32'h0);
            end else begin
                string t;
                logic [31:0] ed;
                logic ee;
                bit cm;
                t = q_tag.pop_front(); ed = q_data.pop_front();
                ee = q_err.pop_front(); cm = q_cmp.pop_front();
                chk({t, " err"}, {31'h0, rsp_err}, {31'h0, ee});
                if (cm) chk({t, " rdata"}, rsp_rdata, ed);
            end
        end
    end

    task automatic acc(bit wr, int cs, int a, logic [31:0] wd, logic [3:0] be, string tag);
        logic [31:0] ed;
        bit ee, cm;
        int base;
        ed = '0; ee = 1'b0; cm = 1'b0;
        base = a & 252;
        if (cs > 5) begin
            ee = 1'b1;
        end else if (wr) begin
            if (!cfg_wp[cs])
                for (int b = 0; b < 4; b++)
                    if (be[b]) shadow[cs*256 + base + b] = wd[8*b +: 8];
        end else begin
            cm = 1'b1;
            for (int b = 0; b < 4; b++) ed[8*b +: 8] = shadow[cs*256 + base + b];
        end
        q_data.push_back(ed); q_err.push_back(ee); q_cmp.push_back(cm); q_tag.push_back(tag);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {3'(cs), 26'(a)};
        req_wdata = wd;
        req_be    = be;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual=busy expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int p0, w0, c0;
        // cs0 wide w0 p0; cs1 narrow w3 p2; cs2 wide w1 p4 ext; cs3 narrow wp; cs4 wide ext; cs5 narrow
        cfg_wide = 6'b010101;
        cfg_wp   = 6'b001000;
        cfg_ext  = 6'b010100;
        cfg_wait = '0; cfg_post = '0;
        cfg_wait[6 +: 6] = 6'd3;  cfg_post[5 +: 5] = 5'd2;
        cfg_wait[12 +: 6] = 6'd1; cfg_post[10 +: 5] = 5'd4;
        cfg_tmo  = 16'd40;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 cs_n", {26'h0, mem_cs_n}, 32'h3f);
        chk("R10 oe_n", {31'h0, mem_oe_n}, 32'h1);
        chk("R10 we_n", {30'h0, mem_we_n}, 32'h3);
        chk("R10 ready", {31'h0, req_ready}, 32'h0);
        chk("R10 flags", {30'h0, wp_err, warm_rst_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: 16-bit device, full and sparse byte enables
        acc(1, 0, 8'h10, 32'hA1B2C3D4, 4'hF, "R2 wide write");
        p0 = oe_pulses;
        acc(0, 0, 8'h10, 0, 4'h0, "R2 wide read");
        chk("R2 beats", oe_pulses - p0, 2);
        chk("R4 wide w0 strobe", last_len, 1);
        chk("R5 wide p0 gap", last_gap, 1);
        acc(1, 0, 8'h13, 32'h11223344, 4'b0101, "R2 sparse write");
        acc(0, 0, 8'h10, 0, 4'h0, "R2 sparse read");

        // R3: 8-bit device
        w0 = we_cycles;
        acc(1, 1, 8'h20, 32'h55667788, 4'b1010, "R3 narrow write");
        chk("R3 we cycles", we_cycles - w0, 8);
        p0 = oe_pulses; w0 = we_cycles;
        acc(0, 1, 8'h20, 0, 4'h0, "R3 narrow read");
        chk("R3 beats", oe_pulses - p0, 4);
        chk("R9 no we on read", we_cycles - w0, 0);
        chk("R4 wait3 strobe", last_len, 4);
        chk("R5 post2 gap", last_gap, 3);
        p0 = oe_pulses;
        acc(1, 5, 8'h44, 32'hCAFEF00D, 4'hF, "R3 narrow w0 write");
        chk("R9 no oe on write", oe_pulses - p0, 0);
        acc(0, 5, 8'h44, 0, 4'h0, "R3 narrow w0 read");

        // R6: external wait extends strobe
        acc(1, 2, 8'h30, 32'h0BADBEEF, 4'hF, "R6 ext write");
        p0 = oe_pulses;
        acc(0, 2, 8'h30, 0, 4'h0, "R6 ext read");
        chk("R6 beats", oe_pulses - p0, 2);
        chk("R6 ext strobe", last_len, 6);
        chk("R5 post4 gap", last_gap, 5);

        // R7: protected write
        c0 = cs_cycles; w0 = we_cycles;
        acc(1, 3, 8'h08, 32'hDEADDEAD, 4'hF, "R7 protected write");
        chk("R7 no bus", cs_cycles - c0, 0);
        chk("R7 no we", we_cycles - w0, 0);
        chk("R7 sticky", {31'h0, wp_err}, 32'h1);
        acc(0, 3, 8'h08, 0, 4'h0, "R7 data kept");
        chk("R7 still sticky", {31'h0, wp_err}, 32'h1);

        // R1: unmapped index
        c0 = cs_cycles;
        acc(0, 6, 8'h00, 0, 4'h0, "R1 unmapped");
        chk("R1 no cs", cs_cycles - c0, 0);
        acc(0, 7, 8'h04, 0, 4'h0, "R1 unmapped 7");
        chk("R8 no warm yet", {31'h0, warm_rst_req}, 32'h0);

        // R8: hung handshake
        force_hang = 1'b1;
        q_data.push_back(0); q_err.push_back(1'b1); q_cmp.push_back(1'b0); q_tag.push_back("R8 abort");
        req_valid = 1'b1; req_write = 1'b0; req_addr = {3'd4, 26'h40}; req_be = 4'hF;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b0;
        chk("R8 released cs", {26'h0, mem_cs_n}, 32'h3f);
        chk("R8 released oe", {31'h0, mem_oe_n}, 32'h1);
        chk("R8 warm", {31'h0, warm_rst_req}, 32'h1);
        force_hang = 1'b0;
        @(negedge clk);
        chk("R9 ready one cycle", {31'h0, req_ready}, 32'h0);
        chk("R8 warm sticky", {31'h0, warm_rst_req}, 32'h1);
        repeat (2) @(negedge clk);
        chk("R9 queue drained", q_tag.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule